// File: doc/BRIEF.md
# Codec Link Frame Timing Generator

This block turns the bit clock that an audio codec supplies into the frame timing of a five-wire serial codec link. At the default sizes, each frame is 256 bit clocks long and carries one audio sample period at 48 kHz. The bit clock runs at 12.288 MHz.

Every frame opens with a 16-clock tag slot. Twelve data slots of 20 clocks each follow it. The tag slot holds the slot-valid flags. Data slots 1 and 2 carry the control and status words, and slots 3 and 4 carry the left and right PCM samples.

The generator drives the frame marker toward the codec. It also tells a separate data core where the link is in the frame:
- the current slot number;
- the bit index inside that slot;
- a strobe on the last clock of each slot;
- a strobe on the last clock of the frame;
- a strobe on the first clock of the frame.

With these signals the data core can load, shift and capture slot contents without counting for itself. Every output comes straight from a flop.

Top module: `codec_frame_timer`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the outputs show frame position 0 after that edge: slot 0, bit 0, `sync_o`=1, `frame_start_o`=1, `slot_end_o`=0 and `frame_end_o`=0. The first edge with `rst` low moves the position to 1.
- R2: `frame_start_o` pulses once every 256 clocks in free run, so one frame lasts exactly 256 clocks.
- R3: `sync_o` is 1 at frame positions 0 to 15 and 0 at positions 16 to 255.
- R4: `slot_o` reads 0 for positions 0 to 15. For positions p of 16 and above it reads 1+(p-16)/20, which counts 1 up to 12. After slot 12 it returns to 0.
- R5: `bit_o` counts 0 to 15 in slot 0 and 0 to 19 in slots 1 to 12, and returns to 0 on the first clock of every slot.
- R6: `slot_end_o` is 1 exactly on the last clock of each slot: bit 15 of slot 0 and bit 19 of the other slots.
- R7: `frame_end_o` is 1 only at position 255, which is bit 19 of slot 12.
- R8: `frame_start_o` is 1 only at position 0.
- R9: Asserting `rst` in the middle of a frame returns the outputs to position 0 at the next edge. Counting then resumes from 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock supplied by the codec |
| rst | input | 1 | Synchronous active-high reset |
| sync_o | output | 1 | Frame marker to the codec, high during the tag slot |
| slot_o | output | 4 | Current slot number, 0 to 12 |
| bit_o | output | 5 | Bit index within the current slot |
| slot_end_o | output | 1 | High on the last clock of a slot |
| frame_end_o | output | 1 | High on the last clock of the frame |
| frame_start_o | output | 1 | High on the first clock of the frame |

## Verification
All outputs are registered and move together, one edge after the state they describe. After N clock edges with `rst` low, every output shows frame position N mod 256. A reset edge forces position 0 at that same edge, with no further latency.

The bench keeps its own position counter, advanced on each rising edge. It compares every output against that counter at the following falling edge, so each result is read exactly one register after its cause. The frame period is measured separately, as the distance between successive frame-start pulses, and that measurement restarts whenever reset intervenes.

// File: rtl/cft_pkg.sv
package cft_pkg;
  localparam int TAG_LEN_DEF   = 16;
  localparam int DATA_LEN_DEF  = 20;
  localparam int DATA_SLOT_DEF = 12;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cft_slot_seq.sv
module cft_slot_seq #(
  parameter int TAG_LEN   = cft_pkg::TAG_LEN_DEF,
  parameter int DATA_LEN  = cft_pkg::DATA_LEN_DEF,
  parameter int DATA_SLOT = cft_pkg::DATA_SLOT_DEF,
  parameter int SW        = $clog2(DATA_SLOT + 1),
  parameter int BW        = $clog2(cft_pkg::max2(TAG_LEN, DATA_LEN))
) (
  input  logic          clk,
  input  logic          rst,
  output logic [SW-1:0] slot_nxt,
  output logic [BW-1:0] bit_nxt
);
  localparam logic [SW-1:0] LAST_SLOT = SW'(DATA_SLOT);
  localparam logic [BW-1:0] TAG_M1    = BW'(TAG_LEN - 1);
  localparam logic [BW-1:0] DATA_M1   = BW'(DATA_LEN - 1);

  logic [SW-1:0] slot_q;
  logic [BW-1:0] bit_q;
  logic [BW-1:0] len_m1;
  logic          at_end;

  assign len_m1 = (slot_q == '0) ? TAG_M1 : DATA_M1;
  assign at_end = (bit_q == len_m1);

  always_comb begin
    if (rst) begin
      slot_nxt = '0;
      bit_nxt  = '0;
    end else if (at_end) begin
      bit_nxt  = '0;
      slot_nxt = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
    end else begin
      bit_nxt  = bit_q + 1'b1;
      slot_nxt = slot_q;
    end
  end

  always_ff @(posedge clk) begin
    slot_q <= slot_nxt;
    bit_q  <= bit_nxt;
  end

  // R5
  bit_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    bit_q <= DATA_M1);
endmodule

// File: rtl/cft_strobe_gen.sv
module cft_strobe_gen #(
  parameter int TAG_LEN   = cft_pkg::TAG_LEN_DEF,
  parameter int DATA_LEN  = cft_pkg::DATA_LEN_DEF,
  parameter int DATA_SLOT = cft_pkg::DATA_SLOT_DEF,
  parameter int SW        = $clog2(DATA_SLOT + 1),
  parameter int BW        = $clog2(cft_pkg::max2(TAG_LEN, DATA_LEN))
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] slot_nxt,
  input  logic [BW-1:0] bit_nxt,
  output logic [SW-1:0] slot_o,
  output logic [BW-1:0] bit_o,
  output logic          sync_o,
  output logic          slot_end_o,
  output logic          frame_end_o,
  output logic          frame_start_o
);
  localparam logic [SW-1:0] LAST_SLOT = SW'(DATA_SLOT);
  localparam logic [BW-1:0] TAG_M1    = BW'(TAG_LEN - 1);
  localparam logic [BW-1:0] DATA_M1   = BW'(DATA_LEN - 1);

  logic          tag_n;
  logic [BW-1:0] len_m1_n;

  assign tag_n    = (slot_nxt == '0);
  assign len_m1_n = tag_n ? TAG_M1 : DATA_M1;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_o        <= '0;
      bit_o         <= '0;
      sync_o        <= 1'b1;
      slot_end_o    <= 1'b0;
      frame_end_o   <= 1'b0;
      frame_start_o <= 1'b1;
    end else begin
      slot_o        <= slot_nxt;
      bit_o         <= bit_nxt;
      sync_o        <= tag_n;
      slot_end_o    <= (bit_nxt == len_m1_n);
      frame_end_o   <= (slot_nxt == LAST_SLOT) && (bit_nxt == DATA_M1);
      frame_start_o <= tag_n && (bit_nxt == '0);
    end
  end
endmodule

// File: rtl/codec_frame_timer.sv
module codec_frame_timer #(
  parameter int TAG_LEN   = cft_pkg::TAG_LEN_DEF,
  parameter int DATA_LEN  = cft_pkg::DATA_LEN_DEF,
  parameter int DATA_SLOT = cft_pkg::DATA_SLOT_DEF,
  parameter int SW        = $clog2(DATA_SLOT + 1),
  parameter int BW        = $clog2(cft_pkg::max2(TAG_LEN, DATA_LEN))
) (
  input  logic          clk,
  input  logic          rst,
  output logic          sync_o,
  output logic [SW-1:0] slot_o,
  output logic [BW-1:0] bit_o,
  output logic          slot_end_o,
  output logic          frame_end_o,
  output logic          frame_start_o
);
  localparam int FRAME_LEN = TAG_LEN + DATA_LEN * DATA_SLOT;
  localparam int GW        = $clog2(FRAME_LEN + 1);

  logic [SW-1:0] slot_nxt;
  logic [BW-1:0] bit_nxt;

  cft_slot_seq #(
    .TAG_LEN(TAG_LEN), .DATA_LEN(DATA_LEN), .DATA_SLOT(DATA_SLOT), .SW(SW), .BW(BW)
  ) i_seq (
    .clk(clk), .rst(rst), .slot_nxt(slot_nxt), .bit_nxt(bit_nxt)
  );

  cft_strobe_gen #(
    .TAG_LEN(TAG_LEN), .DATA_LEN(DATA_LEN), .DATA_SLOT(DATA_SLOT), .SW(SW), .BW(BW)
  ) i_stb (
    .clk(clk), .rst(rst), .slot_nxt(slot_nxt), .bit_nxt(bit_nxt),
    .slot_o(slot_o), .bit_o(bit_o), .sync_o(sync_o),
    .slot_end_o(slot_end_o), .frame_end_o(frame_end_o), .frame_start_o(frame_start_o)
  );

  // Distance since the last frame start, used only by the period check.
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst)                gap_q <= '0;
    else if (frame_start_o) gap_q <= GW'(1);
    else if (gap_q != '0)   gap_q <= gap_q + 1'b1;
  end

  // R2
  frame_period_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_start_o && gap_q != '0) |-> (gap_q == GW'(FRAME_LEN)));

  // R3
  sync_tag_chk: assert property (@(posedge clk) disable iff (rst)
    sync_o == (slot_o == '0));

  // R5
  slot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    slot_end_o |=> (bit_o == '0));

  // R5
  bit_step_chk: assert property (@(posedge clk) disable iff (rst)
    !slot_end_o |=> (bit_o == $past(bit_o) + 1'b1) && $stable(slot_o));

  // R7
  frame_roll_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end_o |=> frame_start_o);

  // R8
  start_pos_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |-> (slot_o == '0) && (bit_o == '0) && sync_o);

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({frame_start_o, frame_end_o}));
endmodule

// File: tb/test_codec_frame_timer.sv
module test_codec_frame_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sync_o, slot_end_o, frame_end_o, frame_start_o;
  logic [3:0] slot_o;
  logic [4:0] bit_o;

  int checks = 0;
  int errors = 0;
  int mpos   = 0;
  bit started   = 0;
  bit last_rst  = 1;
  bit finished  = 0;
  bit mid_reset = 0;
  int cyc = 0;
  int last_start = -1;

  always #5 clk = ~clk;

  codec_frame_timer i_codec_frame_timer (
    .clk(clk), .rst(rst), .sync_o(sync_o), .slot_o(slot_o), .bit_o(bit_o),
    .slot_end_o(slot_end_o), .frame_end_o(frame_end_o), .frame_start_o(frame_start_o)
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (pos %0d)", req, what, act, exp, mpos);
    end
  endtask

  // Behavioural reference: a plain position counter.
  always @(posedge clk) begin
    last_rst <= rst;
    started  <= 1'b1;
    cyc      <= cyc + 1;
    if (rst) mpos <= 0;
    else     mpos <= (mpos + 1) % 256;
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      int eslot, ebit, elen;
      eslot = (mpos < 16) ? 0 : 1 + (mpos - 16) / 20;
      ebit  = (mpos < 16) ? mpos : (mpos - 16) % 20;
      elen  = (eslot == 0) ? 16 : 20;
      if (last_rst) begin
        string rq;
        rq = mid_reset ? "R9" : "R1";
        chk(rq, slot_o, 0, "slot in reset");
        chk(rq, bit_o, 0, "bit in reset");
        chk(rq, sync_o, 1, "sync in reset");
        chk(rq, frame_start_o, 1, "frame_start in reset");
        chk(rq, slot_end_o, 0, "slot_end in reset");
        chk(rq, frame_end_o, 0, "frame_end in reset");
        last_start = -1;
      end else begin
        chk("R3", sync_o, (mpos < 16) ? 1 : 0, "sync");
        chk("R4", slot_o, eslot, "slot");
        chk("R5", bit_o, ebit, "bit");
        chk("R6", slot_end_o, (ebit == elen - 1) ? 1 : 0, "slot_end");
        chk("R7", frame_end_o, (mpos == 255) ? 1 : 0, "frame_end");
        chk("R8", frame_start_o, (mpos == 0) ? 1 : 0, "frame_start");
        if (frame_start_o) begin
          if (last_start >= 0) chk("R2", cyc - last_start, 256, "frame period");
          last_start = cyc;
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (700) @(negedge clk);
    mid_reset = 1'b1;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (600) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule